// File: doc/BRIEF.md
# Dual-Edge Loadable Shift Register

This block is a small register, four bits wide by default, that changes state on every transition of its clock, rising and falling alike. On each edge it does exactly one of four things, chosen by a fixed priority: it clears to zero, takes a parallel word, shifts one place toward the high end with a serial bit entering at bit 0, or keeps its value. The top bit is dropped on a shift. There is no separate serial output. Stages are chained by feeding the top output bit of one stage into the serial input of the next, with the clock and all controls shared.

No flop in the design triggers on both edges. A rising-edge bank and a falling-edge bank each hold a half-state. The visible word is the XOR of the two banks. At its own edge, each bank stores the wanted next word XOR the other bank's current content, so the XOR always equals the intended state. The output depends only on registered values and never on the clock level. An active-low power-on reset clears both banks at once, so the register reads zero from power-up.

Top module: `dual_edge_shreg`

## Requirements
- R1: The register updates on every rising edge and on every falling edge of `clk`, and both edges follow the same priority rules.
- R2: When `sync_clr` is 1 at an edge, `q` becomes all zeros after that edge, whatever `load`, `shift_en`, `ser_in` and `par_in` are.
- R3: When `sync_clr` is 0 and `load` is 1 at an edge, `q` takes `par_in` bit for bit after that edge, and `shift_en` has no effect.
- R4: When `sync_clr` and `load` are 0 and `shift_en` is 1 at an edge, the new `q[0]` is `ser_in`, the new `q[i]` is the old `q[i-1]` for i from 1 to 3, and the old `q[3]` is lost.
- R5: When `sync_clr`, `load` and `shift_en` are all 0 at an edge, `q` keeps its value.
- R6: While `por_n` is 0, `q` reads all zeros, without waiting for a clock edge.
- R7: Two stages wired with the second stage's `ser_in` driven by the first stage's `q[3]`, and with clock and controls in common, act as one 8-bit shifter on shift edges.
- R8: Between clock edges, `q` does not change when the data or control inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both of its edges act on the register. |
| por_n | input | 1 | Active-low power-on clear, asynchronous. |
| sync_clr | input | 1 | Synchronous clear. Highest priority. |
| load | input | 1 | Parallel load. Takes priority over shift. |
| shift_en | input | 1 | Shift enable. |
| ser_in | input | 1 | Serial bit entering bit 0 on a shift. |
| par_in | input | WIDTH | Parallel data word. |
| q | output | WIDTH | Register contents. |

## Verification
Clear, load and shift can all be requested on the same edge. The bench raises `sync_clr` together with `load` and `shift_en`, and separately raises `load` together with `shift_en`, on both rising and falling edges. It then checks that the higher-priority operation alone sets `q`. The rising-edge and falling-edge updates of a single clock period are also exercised back to back, with different operations on each half of the period. Each result is compared with a model that the bench steps once per edge.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } dsr_op_e;
endpackage

// File: rtl/dsr_ctrl.sv
`timescale 1ns/1ps
module dsr_ctrl
    import dsr_pkg::*;
(
    input  logic    sync_clr,
    input  logic    load,
    input  logic    shift_en,
    output dsr_op_e op
);
    // priority: clear, then load, then shift, else hold
    always_comb begin
        if (sync_clr)      op = OP_CLEAR;
        else if (load)     op = OP_LOAD;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_HOLD;
    end
endmodule

// File: rtl/dsr_next.sv
`timescale 1ns/1ps
module dsr_next
    import dsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  dsr_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH-1:0] shifted;

    // one bit moves up per stage; the top bit falls off
    for (genvar i = 0; i < WIDTH; i++) begin : g_shift
        if (i == 0) begin : g_low
            assign shifted[i] = ser_in;
        end else begin : g_up
            assign shifted[i] = cur[i-1];
        end
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = par_in;
            OP_SHIFT: nxt = shifted;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/dsr_bank.sv
`timescale 1ns/1ps
module dsr_bank #(
    parameter int WIDTH  = 4,
    parameter bit RISING = 1'b1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] nxt,
    input  logic [WIDTH-1:0] other,
    output logic [WIDTH-1:0] bank_q
);
    typedef struct packed {
        logic [WIDTH-1:0] half;
    } bank_s;

    bank_s st_d, st_q;

    // store next XOR partner so that partner XOR this bank gives next
    always_comb begin
        st_d.half = nxt ^ other;
    end

    if (RISING) begin : g_rise
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) st_q <= '0;
            else        st_q <= st_d;
        end
    end else begin : g_fall
        always_ff @(negedge clk or negedge por_n) begin
            if (!por_n) st_q <= '0;
            else        st_q <= st_d;
        end
    end

    assign bank_q = st_q.half;
endmodule

// File: rtl/dual_edge_shreg.sv
`timescale 1ns/1ps
module dual_edge_shreg
    import dsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sync_clr,
    input  logic             load,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int NBANK = 2;

    dsr_op_e          op;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] bank_q [NBANK];

    dsr_ctrl u_ctrl (
        .sync_clr (sync_clr),
        .load     (load),
        .shift_en (shift_en),
        .op       (op)
    );

    dsr_next #(.WIDTH(WIDTH)) u_next (
        .op     (op),
        .cur    (cur),
        .ser_in (ser_in),
        .par_in (par_in),
        .nxt    (nxt)
    );

    // bank 0 acts on the rising edge, bank 1 on the falling edge
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dsr_bank #(.WIDTH(WIDTH), .RISING(b == 0)) u_bank (
            .clk    (clk),
            .por_n  (por_n),
            .nxt    (nxt),
            .other  (bank_q[NBANK-1-b]),
            .bank_q (bank_q[b])
        );
    end

    assign cur = bank_q[0] ^ bank_q[1];
    assign q   = cur;
endmodule

// File: rtl/dsr_check.sv
`timescale 1ns/1ps
module dsr_check #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             por_n,
    input logic             sync_clr,
    input logic             load,
    input logic             shift_en,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q
);
    // inputs and state captured at each rising edge, judged at the next falling edge
    logic             rv, r_clr, r_ld, r_en, r_si;
    logic [WIDTH-1:0] r_pi, r_q;
    // same for falling edge, judged at the next rising edge
    logic             fv, f_clr, f_ld, f_en, f_si;
    logic [WIDTH-1:0] f_pi, f_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rv <= 1'b0; r_clr <= 1'b0; r_ld <= 1'b0; r_en <= 1'b0; r_si <= 1'b0;
            r_pi <= '0; r_q <= '0;
        end else begin
            rv <= 1'b1; r_clr <= sync_clr; r_ld <= load; r_en <= shift_en; r_si <= ser_in;
            r_pi <= par_in; r_q <= q;
        end
    end

    always_ff @(negedge clk or negedge por_n) begin
        if (!por_n) begin
            fv <= 1'b0; f_clr <= 1'b0; f_ld <= 1'b0; f_en <= 1'b0; f_si <= 1'b0;
            f_pi <= '0; f_q <= '0;
        end else begin
            fv <= 1'b1; f_clr <= sync_clr; f_ld <= load; f_en <= shift_en; f_si <= ser_in;
            f_pi <= par_in; f_q <= q;
        end
    end

    AST_CLR_AFTER_RISE: assert property (@(negedge clk) disable iff (!por_n)
        (rv && r_clr) |-> (q == '0)); // R2
    AST_LOAD_AFTER_RISE: assert property (@(negedge clk) disable iff (!por_n)
        (rv && !r_clr && r_ld) |-> (q == r_pi)); // R3
    AST_SHIFT_AFTER_RISE: assert property (@(negedge clk) disable iff (!por_n)
        (rv && !r_clr && !r_ld && r_en) |-> (q == {r_q[WIDTH-2:0], r_si})); // R4
    AST_HOLD_AFTER_RISE: assert property (@(negedge clk) disable iff (!por_n)
        (rv && !r_clr && !r_ld && !r_en) |-> (q == r_q)); // R5

    AST_CLR_AFTER_FALL: assert property (@(posedge clk) disable iff (!por_n)
        (fv && f_clr) |-> (q == '0)); // R1
    AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (!por_n)
        (fv && !f_clr && f_ld) |-> (q == f_pi)); // R1
    AST_SHIFT_AFTER_FALL: assert property (@(posedge clk) disable iff (!por_n)
        (fv && !f_clr && !f_ld && f_en) |-> (q == {f_q[WIDTH-2:0], f_si})); // R1
    AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!por_n)
        (fv && !f_clr && !f_ld && !f_en) |-> (q == f_q)); // R1
endmodule

bind dual_edge_shreg dsr_check #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .sync_clr (sync_clr),
    .load     (load),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .q        (q)
);

// File: tb/sim_dual_edge_shreg.sv
`timescale 1ns/1ps
module sim_dual_edge_shreg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         sync_clr = 1'b0, load = 1'b0, shift_en = 1'b0, ser_in = 1'b0;
    logic [W-1:0] par_in = '0, par_in_b = '0;
    logic [W-1:0] q0, q1;
    logic [W-1:0] m0 = '0, m1 = '0;
    int           n_chk = 0, n_fail = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_edge_shreg #(.WIDTH(W)) u0 (
        .clk(clk), .por_n(por_n), .sync_clr(sync_clr), .load(load),
        .shift_en(shift_en), .ser_in(ser_in), .par_in(par_in), .q(q0)
    );
    // second stage of a cascade: serial input from u0 top bit (R7)
    dual_edge_shreg #(.WIDTH(W)) u1 (
        .clk(clk), .por_n(por_n), .sync_clr(sync_clr), .load(load),
        .shift_en(shift_en), .ser_in(q0[W-1]), .par_in(par_in_b), .q(q1)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic c, l, e, s,
                                           input logic [W-1:0] p);
        if (c)      return '0;
        else if (l) return p;
        else if (e) return {cur[W-2:0], s};
        else        return cur;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // called mid-phase; drives inputs, waits one edge of either polarity, checks both stages
    task automatic step(input logic c, l, e, s, input logic [W-1:0] p, input string req);
        logic [W-1:0] e0, e1;
        sync_clr = c; load = l; shift_en = e; ser_in = s; par_in = p; par_in_b = ~p;
        e0 = model(m0, c, l, e, s, p);
        e1 = model(m1, c, l, e, m0[W-1], ~p);
        @(posedge clk or negedge clk);
        #2;
        m0 = e0; m1 = e1;
        chk(req, q0, m0);
        chk(req, q1, m1);
    endtask

    task automatic t_reset;
        #3;
        chk("R6", q0, '0);
        chk("R6", q1, '0);
        @(negedge clk); #2;
        por_n = 1'b1;
        m0 = '0; m1 = '0;
        chk("R6", q0, '0);
    endtask

    task automatic t_both_edges;
        // one load on the rising edge, a different one on the falling edge
        while (clk !== 1'b0) #1;
        step(0, 1, 0, 0, 4'hA, "R1");
        step(0, 1, 0, 0, 4'h5, "R1");
        step(0, 0, 1, 1, 4'h0, "R1");
        step(0, 0, 1, 0, 4'h0, "R1");
    endtask

    task automatic t_shift;
        step(0, 1, 0, 0, 4'h9, "R4");
        step(0, 0, 1, 1, 4'h0, "R4");
        step(0, 0, 1, 0, 4'h0, "R4");
        step(0, 0, 1, 1, 4'h0, "R4");
        step(0, 0, 1, 1, 4'h0, "R4");
        step(0, 0, 1, 0, 4'h0, "R4");
    endtask

    task automatic t_hold;
        step(0, 1, 0, 0, 4'hC, "R5");
        step(0, 0, 0, 1, 4'h3, "R5");
        step(0, 0, 0, 0, 4'hF, "R5");
        step(0, 0, 0, 1, 4'h6, "R5");
    endtask

    task automatic t_clear_priority;
        step(0, 1, 0, 0, 4'hF, "R2");
        step(1, 1, 1, 1, 4'hE, "R2");
        step(0, 1, 0, 0, 4'h7, "R2");
        step(1, 0, 1, 1, 4'h0, "R2");
        step(1, 0, 0, 0, 4'h0, "R2");
    endtask

    task automatic t_load_priority;
        step(0, 0, 1, 1, 4'h0, "R3");
        step(0, 1, 1, 1, 4'h2, "R3");
        step(0, 1, 1, 0, 4'hD, "R3");
        step(0, 1, 0, 1, 4'h8, "R3");
    endtask

    task automatic t_cascade;
        logic [7:0] pat = 8'b1011_0010;
        step(1, 0, 0, 0, 4'h0, "R7");
        for (int i = 7; i >= 0; i--) step(0, 0, 1, pat[i], 4'h0, "R7");
        chk("R7", {q1, q0}, pat);
    endtask

    task automatic t_stable;
        logic [W-1:0] s0;
        step(0, 1, 0, 0, 4'h6, "R8");
        s0 = q0;
        #1;
        par_in = 4'h9; ser_in = 1'b1; shift_en = 1'b1; load = 1'b1;
        #0.5;
        chk("R8", q0, s0);
        sync_clr = 1'b1;
        #0.3;
        chk("R8", q0, s0);
        @(posedge clk or negedge clk); #2;
        m0 = '0; m1 = '0;
        chk("R2", q0, '0);
        step(0, 1, 0, 0, 4'h3, "R8");
        por_n = 1'b0;
        #0.5;
        chk("R6", q0, '0);
        chk("R6", q1, '0);
        #1;
        por_n = 1'b1;
        m0 = '0; m1 = '0;
        step(0, 0, 0, 0, 4'h0, "R6");
    endtask

    initial begin
        t_reset();
        t_both_edges();
        t_shift();
        t_hold();
        t_clear_priority();
        t_load_priority();
        t_cascade();
        t_stable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule